// File: doc/BRIEF.md
# Reservation Monitor for Load-Reserved / Store-Conditional

This block keeps the load-reserved address reservations of several hardware threads that share one memory, and it decides whether each store-conditional succeeds. Every cycle each thread can present one event on its own lane: a load-reserved, a store-conditional, an ordinary store, or nothing. Each event comes with a byte address. The monitor holds one reservation per thread, compared at 64-byte line granularity. It reports a result code for every store-conditional one cycle after the store-conditional is issued. It also broadcasts one invalidation per thread lane, which stands in for a coherence bus.

A load-reserved does not drop the matching reservations of other threads at once. Those losses are held back for a bounded window of `DEFER` cycles. This gives the thread that already holds the line a chance to finish its pair, so two threads that keep reserving the same line cannot starve each other. Writes are different: a successful store-conditional or an ordinary store by another thread cancels a matching reservation at once. This keeps every update of a line atomic.

Top module: `rsv_monitor`

## Requirements
- R1: While reset is applied and until the first event after it, `resv_valid_o`, `sc_done_o`, `sc_fail_o` and `inv_valid_o` are all zero.
- R2: Lane i of `op_i` sits at bits [2i+1:2i], with the codes 0 for idle, 1 for load-reserved, 2 for store-conditional and 3 for store. A load-reserved on lane i sets `resv_valid_o[i]` in the next cycle. In that same cycle it raises `inv_valid_o[i]`, with `inv_line_o` lane i equal to address bits [AW-1:6].
- R3: A store-conditional raises `sc_done_o[i]` in the next cycle. `sc_fail_o[i]` then carries the result code: 0 if thread i held a reservation on the same line, and 1 otherwise.
- R4: Two addresses match when they differ only in their low 6 bits.
- R5: A store-conditional clears the issuing thread's reservation, whether it succeeds or fails.
- R6: A successful store-conditional or an ordinary store on lane j cancels any matching reservation of every other thread in the next cycle.
- R7: When another thread issues a load-reserved on a reserved line, the holder keeps its reservation for up to `DEFER` cycles. A store-conditional by the holder issued within that window succeeds.
- R8: A held invalidation takes effect `DEFER` cycles after the load-reserved that caused it, even if no store-conditional arrives. Further load-reserved events on the same line during the window do not restart it.
- R9: When several threads issue a store-conditional to the same line in the same cycle, only the one with the lowest index can succeed. A store-conditional also fails if another thread issues an ordinary store to the same line in that cycle.
- R10: A new load-reserved by a thread replaces its reservation and cancels any held invalidation on the old one.
- R11: A thread's own ordinary store, and stores by any thread to other lines, leave its reservation in place. A failed store-conditional does not raise `inv_valid_o`, while an ordinary store does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op_i | input | 2*NTHR | Per-lane event code: 0 idle, 1 load-reserved, 2 store-conditional, 3 store |
| addr_i | input | AW*NTHR | Per-lane byte address |
| sc_done_o | output | NTHR | Store-conditional result valid, one cycle after issue |
| sc_fail_o | output | NTHR | Store-conditional result code (0 success, 1 failure) |
| resv_valid_o | output | NTHR | Thread currently holds a reservation |
| inv_valid_o | output | NTHR | Invalidation broadcast from each lane |
| inv_line_o | output | (AW-6)*NTHR | Line address of each lane's broadcast |

## Verification
The bench targets the deferral window edges. It issues a store-conditional on the last cycle inside the window and checks the reservation in the cycle the window closes. A timer off by one, or one that restarts on every competing load-reserved, would keep a stale reservation or drop a live one a cycle early. It also drives same-cycle store-conditional races and store-versus-store-conditional collisions. A design without the lowest-index rule would let two threads both succeed on one line. Offsets inside a line, a thread's own stores and failed store-conditionals are driven too: a design that compared full addresses, cancelled on self-stores or broadcast on failure would show it on `sc_fail_o`, `resv_valid_o` or `inv_valid_o`.

// File: rtl/rsv_pkg.sv
package rsv_pkg;
  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_LR   = 2'd1,
    OP_SC   = 2'd2,
    OP_ST   = 2'd3
  } rsv_op_e;
endpackage

// File: rtl/rsv_entry.sv
// One thread's reservation with its deferred-invalidation timer.
module rsv_entry
  import rsv_pkg::*;
#(
  parameter int LW    = 26,
  parameter int DEFER = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  rsv_op_e       op,
  input  logic [LW-1:0] line_in,
  input  logic          kill_now,
  input  logic          kill_defer,
  output logic          valid_o,
  output logic [LW-1:0] line_o
);
  localparam int CW = (DEFER > 1) ? $clog2(DEFER) : 1;

  logic          valid_q, valid_d;
  logic          pend_q, pend_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [LW-1:0] line_q;
  logic          line_en;

  always_comb begin
    valid_d = valid_q;
    pend_d  = pend_q;
    cnt_d   = cnt_q;
    line_en = 1'b0;
    if (op == OP_LR) begin
      valid_d = 1'b1;
      pend_d  = 1'b0;
      cnt_d   = '0;
      line_en = 1'b1;
    end else if (op == OP_SC || kill_now) begin
      valid_d = 1'b0;
      pend_d  = 1'b0;
      cnt_d   = '0;
    end else if (pend_q) begin
      if (cnt_q == '0) begin
        valid_d = 1'b0;
        pend_d  = 1'b0;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end else if (kill_defer && valid_q) begin
      pend_d = 1'b1;
      cnt_d  = CW'(DEFER - 1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      pend_q  <= 1'b0;
      cnt_q   <= '0;
      line_q  <= '0;
    end else begin
      valid_q <= valid_d;
      pend_q  <= pend_d;
      cnt_q   <= cnt_d;
      if (line_en) line_q <= line_in;
    end
  end

  assign valid_o = valid_q;
  assign line_o  = line_q;
endmodule

// File: rtl/rsv_arbiter.sv
// Same-cycle resolution: store-conditional winners and kill requests.
module rsv_arbiter
  import rsv_pkg::*;
#(
  parameter int NTHR = 4,
  parameter int LW   = 26
) (
  input  logic [2*NTHR-1:0]  ops,
  input  logic [NTHR*LW-1:0] lines,
  input  logic [NTHR-1:0]    resv_valid,
  input  logic [NTHR*LW-1:0] resv_lines,
  output logic [NTHR-1:0]    sc_ok,
  output logic [NTHR-1:0]    kill_now,
  output logic [NTHR-1:0]    kill_defer
);
  logic [NTHR-1:0] cand;
  logic [NTHR-1:0] wr;

  always_comb begin
    for (int i = 0; i < NTHR; i++) begin
      cand[i] = (ops[2*i +: 2] == OP_SC) && resv_valid[i] &&
                (resv_lines[i*LW +: LW] == lines[i*LW +: LW]);
    end
  end

  always_comb begin
    for (int i = 0; i < NTHR; i++) begin
      sc_ok[i] = cand[i];
      for (int j = 0; j < NTHR; j++) begin
        if (j != i && lines[j*LW +: LW] == lines[i*LW +: LW]) begin
          if (ops[2*j +: 2] == OP_ST) sc_ok[i] = 1'b0;
          if (j < i && cand[j])       sc_ok[i] = 1'b0;
        end
      end
      wr[i] = (ops[2*i +: 2] == OP_ST) || sc_ok[i];
    end
  end

  always_comb begin
    for (int k = 0; k < NTHR; k++) begin
      kill_now[k]   = 1'b0;
      kill_defer[k] = 1'b0;
      for (int i = 0; i < NTHR; i++) begin
        if (i != k && resv_valid[k] &&
            lines[i*LW +: LW] == resv_lines[k*LW +: LW]) begin
          if (wr[i])                    kill_now[k]   = 1'b1;
          if (ops[2*i +: 2] == OP_LR)   kill_defer[k] = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rsv_report.sv
// Registered result codes and invalidation broadcast per lane.
module rsv_report
  import rsv_pkg::*;
#(
  parameter int NTHR = 4,
  parameter int LW   = 26
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [2*NTHR-1:0]  ops,
  input  logic [NTHR*LW-1:0] lines,
  input  logic [NTHR-1:0]    sc_ok,
  output logic [NTHR-1:0]    sc_done_o,
  output logic [NTHR-1:0]    sc_fail_o,
  output logic [NTHR-1:0]    inv_valid_o,
  output logic [NTHR*LW-1:0] inv_line_o
);
  logic [NTHR-1:0] done_d, fail_d, inv_d;

  always_comb begin
    for (int i = 0; i < NTHR; i++) begin
      done_d[i] = (ops[2*i +: 2] == OP_SC);
      fail_d[i] = done_d[i] && !sc_ok[i];
      inv_d[i]  = (ops[2*i +: 2] == OP_LR) || (ops[2*i +: 2] == OP_ST) || sc_ok[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sc_done_o   <= '0;
      sc_fail_o   <= '0;
      inv_valid_o <= '0;
    end else begin
      sc_done_o   <= done_d;
      sc_fail_o   <= fail_d;
      inv_valid_o <= inv_d;
    end
  end

  for (genvar g = 0; g < NTHR; g++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       inv_line_o[g*LW +: LW] <= '0;
      else if (inv_d[g]) inv_line_o[g*LW +: LW] <= lines[g*LW +: LW];
    end
  end
endmodule

// File: rtl/rsv_monitor.sv
module rsv_monitor
  import rsv_pkg::*;
#(
  parameter int NTHR       = 4,
  parameter int AW         = 32,
  parameter int LINE_BYTES = 64,
  parameter int DEFER      = 16
) (
  input  logic                              clk,
  input  logic                              rst_ni,
  input  logic [2*NTHR-1:0]                 op_i,
  input  logic [AW*NTHR-1:0]                addr_i,
  output logic [NTHR-1:0]                   sc_done_o,
  output logic [NTHR-1:0]                   sc_fail_o,
  output logic [NTHR-1:0]                   resv_valid_o,
  output logic [NTHR-1:0]                   inv_valid_o,
  output logic [(AW-$clog2(LINE_BYTES))*NTHR-1:0] inv_line_o
);
  localparam int OFFB = $clog2(LINE_BYTES);
  localparam int LW   = AW - OFFB;

  logic [1:0]         rst_sync_q;
  logic               rst_sync_n;
  logic [NTHR*LW-1:0] lines;
  logic [NTHR*LW-1:0] resv_lines;
  logic [NTHR-1:0]    sc_ok, kill_now, kill_defer;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= '0;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  for (genvar g = 0; g < NTHR; g++) begin : g_thr
    assign lines[g*LW +: LW] = addr_i[g*AW + OFFB +: LW];

    rsv_entry #(.LW(LW), .DEFER(DEFER)) u_entry (
      .clk        (clk),
      .rst_n      (rst_sync_n),
      .op         (rsv_op_e'(op_i[2*g +: 2])),
      .line_in    (lines[g*LW +: LW]),
      .kill_now   (kill_now[g]),
      .kill_defer (kill_defer[g]),
      .valid_o    (resv_valid_o[g]),
      .line_o     (resv_lines[g*LW +: LW])
    );
  end

  rsv_arbiter #(.NTHR(NTHR), .LW(LW)) u_arb (
    .ops        (op_i),
    .lines      (lines),
    .resv_valid (resv_valid_o),
    .resv_lines (resv_lines),
    .sc_ok      (sc_ok),
    .kill_now   (kill_now),
    .kill_defer (kill_defer)
  );

  rsv_report #(.NTHR(NTHR), .LW(LW)) u_rep (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .ops         (op_i),
    .lines       (lines),
    .sc_ok       (sc_ok),
    .sc_done_o   (sc_done_o),
    .sc_fail_o   (sc_fail_o),
    .inv_valid_o (inv_valid_o),
    .inv_line_o  (inv_line_o)
  );
endmodule

// File: rtl/rsv_monitor_chk.sv
module rsv_monitor_chk #(
  parameter int NTHR       = 4,
  parameter int AW         = 32,
  parameter int LINE_BYTES = 64
) (
  input logic               clk,
  input logic               rst_n,
  input logic [2*NTHR-1:0]  op_i,
  input logic [AW*NTHR-1:0] addr_i,
  input logic [NTHR-1:0]    sc_done_o,
  input logic [NTHR-1:0]    sc_fail_o,
  input logic [NTHR-1:0]    resv_valid_o,
  input logic [NTHR-1:0]    inv_valid_o
);
  localparam int OFFB = $clog2(LINE_BYTES);
  localparam int LW   = AW - OFFB;

  assert_fail_implies_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_fail_o & ~sc_done_o) == '0);

  for (genvar g = 0; g < NTHR; g++) begin : g_a
    assert_lr_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
      op_i[2*g +: 2] == 2'd1 |=> resv_valid_o[g] && inv_valid_o[g]);
    assert_sc_reported_R3: assert property (@(posedge clk) disable iff (!rst_n)
      op_i[2*g +: 2] == 2'd2 |=> sc_done_o[g]);
    assert_no_resv_fails_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i[2*g +: 2] == 2'd2 && !resv_valid_o[g]) |=> sc_fail_o[g]);
    assert_sc_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
      op_i[2*g +: 2] == 2'd2 |=> !resv_valid_o[g]);
    for (genvar h = g + 1; h < NTHR; h++) begin : g_p
      assert_single_winner_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i[2*g +: 2] == 2'd2 && op_i[2*h +: 2] == 2'd2 &&
         addr_i[g*AW + OFFB +: LW] == addr_i[h*AW + OFFB +: LW])
        |=> (sc_fail_o[g] || sc_fail_o[h]));
    end
  end
endmodule

bind rsv_monitor rsv_monitor_chk #(
  .NTHR(NTHR), .AW(AW), .LINE_BYTES(LINE_BYTES)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .op_i         (op_i),
  .addr_i       (addr_i),
  .sc_done_o    (sc_done_o),
  .sc_fail_o    (sc_fail_o),
  .resv_valid_o (resv_valid_o),
  .inv_valid_o  (inv_valid_o)
);

// File: tb/rsv_monitor_test.sv
module rsv_monitor_test;
  localparam int NTHR  = 4;
  localparam int AW    = 32;
  localparam int DEFER = 16;
  localparam int LW    = AW - 6;
  localparam logic [1:0] NONE = 2'd0, LR = 2'd1, SC = 2'd2, ST = 2'd3;
  localparam logic [AW-1:0] LA = 32'h0000_1000, LB = 32'h0000_2000, LC = 32'h0000_3000;

  logic                 clk;
  logic                 rst_ni;
  logic [2*NTHR-1:0]    drv_ops;
  logic [AW*NTHR-1:0]   drv_addr;
  logic [NTHR-1:0]      sc_done, sc_fail, resv_valid, inv_valid;
  logic [LW*NTHR-1:0]   inv_line;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;
  int ecount = 0;

  logic            m_valid [NTHR];
  logic [LW-1:0]   m_line  [NTHR];
  logic            m_pend  [NTHR];
  int              m_dead  [NTHR];
  logic [NTHR-1:0] e_done, e_fail, e_inv;
  logic [LW-1:0]   e_line  [NTHR];

  rsv_monitor #(.NTHR(NTHR), .AW(AW), .LINE_BYTES(64), .DEFER(DEFER)) uut (
    .clk(clk), .rst_ni(rst_ni), .op_i(drv_ops), .addr_i(drv_addr),
    .sc_done_o(sc_done), .sc_fail_o(sc_fail), .resv_valid_o(resv_valid),
    .inv_valid_o(inv_valid), .inv_line_o(inv_line));

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < NTHR; i++) begin
      m_valid[i] = 1'b0; m_line[i] = '0; m_pend[i] = 1'b0; m_dead[i] = 0; e_line[i] = '0;
    end
    e_done = '0; e_fail = '0; e_inv = '0;
  endtask

  // Expected behaviour derived from the requirement list.
  task automatic model_step();
    logic [1:0]    op [NTHR];
    logic [LW-1:0] ln [NTHR];
    logic ok [NTHR];
    logic wr [NTHR];
    logic kn, kd;
    ecount++;
    for (int i = 0; i < NTHR; i++) begin
      op[i] = drv_ops[2*i +: 2];
      ln[i] = drv_addr[AW*i + 6 +: LW];
    end
    for (int i = 0; i < NTHR; i++) begin
      ok[i] = (op[i] == SC) && m_valid[i] && m_line[i] == ln[i];
      for (int j = 0; j < NTHR; j++)
        if (j != i && ln[j] == ln[i]) begin
          if (op[j] == ST) ok[i] = 1'b0;
          if (j < i && op[j] == SC && m_valid[j] && m_line[j] == ln[j]) ok[i] = 1'b0;
        end
    end
    for (int i = 0; i < NTHR; i++) wr[i] = (op[i] == ST) || ok[i];
    for (int k = 0; k < NTHR; k++) begin
      kn = 1'b0; kd = 1'b0;
      for (int i = 0; i < NTHR; i++)
        if (i != k && m_valid[k] && ln[i] == m_line[k]) begin
          if (wr[i]) kn = 1'b1;
          if (op[i] == LR) kd = 1'b1;
        end
      e_done[k] = (op[k] == SC);
      e_fail[k] = (op[k] == SC) && !ok[k];
      e_inv[k]  = (op[k] == LR) || (op[k] == ST) || ok[k];
      if (e_inv[k]) e_line[k] = ln[k];
      if (op[k] == LR) begin
        m_valid[k] = 1'b1; m_line[k] = ln[k]; m_pend[k] = 1'b0;
      end else if (op[k] == SC || kn) begin
        m_valid[k] = 1'b0; m_pend[k] = 1'b0;
      end else if (m_pend[k]) begin
        if (ecount == m_dead[k]) begin m_valid[k] = 1'b0; m_pend[k] = 1'b0; end
      end else if (kd && m_valid[k]) begin
        m_pend[k] = 1'b1; m_dead[k] = ecount + DEFER;
      end
    end
  endtask

  task automatic compare(input string tag);
    logic [NTHR-1:0] ev;
    for (int i = 0; i < NTHR; i++) ev[i] = m_valid[i];
    chk({tag, " sc_done"}, 64'(sc_done), 64'(e_done));
    chk({tag, " sc_fail"}, 64'(sc_fail), 64'(e_fail));
    chk({tag, " resv_valid"}, 64'(resv_valid), 64'(ev));
    chk({tag, " inv_valid"}, 64'(inv_valid), 64'(e_inv));
    for (int i = 0; i < NTHR; i++)
      if (e_inv[i]) chk({tag, " inv_line"}, 64'(inv_line[i*LW +: LW]), 64'(e_line[i]));
  endtask

  task automatic clr();
    drv_ops = '0; drv_addr = '0;
  endtask

  task automatic put(input int t, input logic [1:0] op, input logic [AW-1:0] a);
    drv_ops[2*t +: 2] = op; drv_addr[AW*t +: AW] = a;
  endtask

  task automatic tick(input string tag);
    model_step();
    @(negedge clk);
    compare(tag);
    clr();
  endtask

  task automatic idle(input int n, input string tag);
    for (int k = 0; k < n; k++) tick(tag);
  endtask

  task automatic flush();
    for (int t = 0; t < NTHR; t++) put(t, SC, 32'h0);
    tick("R5 flush");
    tick("R1 flush idle");
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog expired R1 actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7741));
    rst_ni = 1'b0;
    clr();
    model_reset();
    repeat (3) @(negedge clk);
    chk("R1 reset resv", 64'(resv_valid), 64'd0);
    chk("R1 reset done", 64'(sc_done), 64'd0);
    chk("R1 reset inv", 64'(inv_valid), 64'd0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 after release", 64'({resv_valid, sc_done, sc_fail, inv_valid}), 64'd0);

    // R2 / R3 / R4 / R5
    put(0, LR, LA); tick("R2 lr");
    chk("R2 resv", 64'(resv_valid[0]), 64'd1);
    chk("R2 inv_line", 64'(inv_line[0 +: LW]), 64'(LA >> 6));
    put(0, SC, LA + 32'h20); tick("R4 sc offset");
    chk("R4 sc success", 64'({sc_done[0], sc_fail[0]}), 64'b10);
    chk("R5 cleared", 64'(resv_valid[0]), 64'd0);
    put(0, SC, LA); tick("R3 sc no resv");
    chk("R3 fail code", 64'(sc_fail[0]), 64'd1);
    put(1, LR, LB); tick("R2 lr B");
    put(1, SC, LC); tick("R3 wrong line");
    chk("R3 wrong line fail", 64'(sc_fail[1]), 64'd1);
    chk("R5 cleared on fail", 64'(resv_valid[1]), 64'd0);
    flush();

    // R6 store by another thread
    put(0, LR, LB); tick("R6 lr");
    put(1, ST, LB + 32'h8); tick("R6 store");
    chk("R6 killed", 64'(resv_valid[0]), 64'd0);
    put(0, SC, LB); tick("R6 sc after kill");
    chk("R6 sc fails", 64'(sc_fail[0]), 64'd1);
    flush();

    // R7 deferral, then R6 kill by successful SC
    put(0, LR, LA); tick("R7 lr0");
    put(1, LR, LA + 32'h4); tick("R7 lr1");
    idle(5, "R7 wait");
    chk("R7 held", 64'(resv_valid[0]), 64'd1);
    put(0, SC, LA); tick("R7 sc0");
    chk("R7 sc within window", 64'(sc_fail[0]), 64'd0);
    chk("R6 sc kills other", 64'(resv_valid[1]), 64'd0);
    put(1, SC, LA); tick("R6 sc1");
    chk("R6 sc1 fails", 64'(sc_fail[1]), 64'd1);
    flush();

    // R8 expiry, window not restarted
    put(0, LR, LA); tick("R8 lr0");
    put(1, LR, LA); tick("R8 lr1");
    idle(2, "R8 wait");
    put(2, LR, LA); tick("R8 lr2");
    idle(DEFER - 4, "R8 wait");
    chk("R8 last cycle held", 64'(resv_valid[0]), 64'd1);
    tick("R8 expire");
    chk("R8 expired", 64'(resv_valid[0]), 64'd0);
    flush();

    // R8 SC on last cycle of window
    put(0, LR, LC); tick("R8 lr0");
    put(3, LR, LC); tick("R8 lr3");
    idle(DEFER - 1, "R8 wait");
    put(0, SC, LC); tick("R8 sc last");
    chk("R8 sc at window end", 64'(sc_fail[0]), 64'd0);
    flush();

    // R9 same-cycle races
    put(0, LR, LA); tick("R9 lr0");
    put(1, LR, LA); tick("R9 lr1");
    put(0, SC, LA); put(1, SC, LA); tick("R9 race");
    chk("R9 lowest wins", 64'({sc_fail[1], sc_fail[0]}), 64'b10);
    put(2, LR, LB); tick("R9 lr2");
    put(2, SC, LB); put(3, ST, LB + 32'h3c); tick("R9 store race");
    chk("R9 store beats sc", 64'(sc_fail[2]), 64'd1);
    flush();

    // R10 new LR replaces and cancels deferral
    put(0, LR, LA); tick("R10 lr0");
    put(1, LR, LA); tick("R10 lr1");
    put(0, LR, LB); tick("R10 relr");
    idle(DEFER + 2, "R10 wait");
    chk("R10 still held", 64'(resv_valid[0]), 64'd1);
    put(0, SC, LB); tick("R10 sc");
    chk("R10 sc ok", 64'(sc_fail[0]), 64'd0);
    flush();

    // R11 own store and other lines
    put(0, LR, LA); tick("R11 lr");
    put(0, ST, LA); tick("R11 own st");
    chk("R11 own store keeps", 64'(resv_valid[0]), 64'd1);
    put(1, ST, LB); tick("R11 other line");
    chk("R11 other line keeps", 64'(resv_valid[0]), 64'd1);
    chk("R11 store broadcasts", 64'(inv_valid[1]), 64'd1);
    put(2, SC, LA); tick("R11 failed sc");
    chk("R11 failed sc silent", 64'(inv_valid[2]), 64'd0);
    flush();

    // Random mix against the model
    for (int n = 0; n < 4000; n++) begin
      for (int t = 0; t < NTHR; t++) begin
        logic [AW-1:0] a;
        logic [1:0] o;
        int r;
        r = int'($urandom % 10);
        o = (r < 4) ? NONE : (r < 6) ? LR : (r < 9) ? SC : ST;
        a = 32'h1000 * (1 + ($urandom % 3)) + ($urandom % 64);
        put(t, o, a);
      end
      tick("R6 R7 R8 R9 random");
    end

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule